// File: doc/BRIEF.md
# Per-Pixel Bitmap Compositor

This block holds three one-bit-per-pixel bitmaps of 32 rows by 32 columns: a working buffer, an image plane and a displayed screen plane. Each plane is a 1024-bit register. A compose command merges the buffer with the image pixel by pixel through a 4-bit boolean code. The code is a full two-input truth table, so one small multiplexer per pixel covers every operation: clear, fill, draw, erase, toggle, the transparent (alpha) forms and the inverted forms. The result is written in a single cycle to either the buffer or the image plane.

A flush command copies the buffer into the screen plane in one cycle, which gives double-buffered display. The image plane is filled through a whole-plane load input, which stands in for whatever sprite source sits upstream. The three planes are output as flat vectors. Row r occupies bits [r*32 +: 32], and column c of that row is bit c within the row word.

At most one command takes effect per clock. Flush has the highest priority, compose comes next, and image load has the lowest.

Top module: `bitmap_compositor`

## Requirements
- R1: After reset, the buffer, image and screen planes are all zero.
- R2: For every pixel, let s be the buffer bit and b be the image bit at the same position. The composed bit is func_code[{b,s}]: bit 0 when s=0,b=0; bit 1 when s=1,b=0; bit 2 when s=0,b=1; bit 3 when s=1,b=1.
- R3: Code 4'b0000 yields an all-zero plane and code 4'b1111 yields an all-one plane, whatever the inputs.
- R4: The named codes give these results: 4'b1010 keeps s, 4'b1100 gives b, 4'b0110 gives s XOR b, 4'b1110 gives s OR b, 4'b0010 gives s AND NOT b, 4'b0111 gives NAND, 4'b0001 gives NOR, and 4'b0101 gives NOT s.
- R5: A start pulse with dest_sel=0 writes the result to the buffer and leaves the image unchanged. With dest_sel=1 it writes the result to the image and leaves the buffer unchanged. The result is visible after the clock edge that samples start.
- R6: A flush pulse copies the buffer into the screen plane at the sampling edge and leaves the buffer and image unchanged.
- R7: When flush and start are high in the same cycle, only the flush takes effect, and the buffer and image keep their values.
- R8: img_load with neither flush nor start replaces the image with img_data at the next edge. When flush or start is high in the same cycle, the load is ignored.
- R9: In a cycle with no flush, start or img_load, all three planes hold their values.
- R10: The screen plane changes only as the result of a flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| func_code | input | 4 | Per-pixel truth table used by compose |
| dest_sel | input | 1 | Compose destination: 0 buffer, 1 image |
| start | input | 1 | Compose strobe |
| flush | input | 1 | Copy buffer to screen |
| img_load | input | 1 | Replace image with img_data |
| img_data | input | 1024 | Image load value, row r at bits [r*32 +: 32] |
| buf_plane | output | 1024 | Buffer plane register |
| img_plane | output | 1024 | Image plane register |
| scr_plane | output | 1024 | Screen plane register |

## Verification
The assertions watch the command priority on every cycle. Each cycle they confirm that the screen moves only on a flush and then takes the buffer's previous value, that a flush freezes the buffer and image even when a compose is strobed with it, that the unselected compose destination holds, and that idle cycles hold every plane. Only the bench scenarios can show that the pixel values produced by each of the sixteen codes are correct. The bench compares them against a truth-table model and against explicit boolean forms for the named codes, using random and structured patterns. The bench scenarios are also what show the reset contents and that a load is dropped when it collides with another command.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FLUSH,
    OP_COMP_BUF,
    OP_COMP_IMG,
    OP_LOAD
  } bmc_op_e;

  localparam logic [3:0] FN_CLEAR  = 4'b0000;
  localparam logic [3:0] FN_FULL   = 4'b1111;
  localparam logic [3:0] FN_KEEP   = 4'b1010;
  localparam logic [3:0] FN_DRAW   = 4'b1100;
  localparam logic [3:0] FN_TOGGLE = 4'b0110;

endpackage

// File: rtl/bmc_reset_sync.sv
module bmc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bmc_cmd_arb.sv
module bmc_cmd_arb
  import bmc_pkg::*;
(
  input  logic    flush,
  input  logic    start,
  input  logic    dest_sel,
  input  logic    img_load,
  output bmc_op_e op,
  output logic    scr_en,
  output logic    buf_en,
  output logic    img_en,
  output logic    img_from_load
);
  always_comb begin
    if (flush)                op = OP_FLUSH;
    else if (start && !dest_sel) op = OP_COMP_BUF;
    else if (start)           op = OP_COMP_IMG;
    else if (img_load)        op = OP_LOAD;
    else                      op = OP_IDLE;
  end

  always_comb begin
    scr_en        = (op == OP_FLUSH);
    buf_en        = (op == OP_COMP_BUF);
    img_en        = (op == OP_COMP_IMG) || (op == OP_LOAD);
    img_from_load = (op == OP_LOAD);
  end
endmodule

// File: rtl/bmc_row_op.sv
module bmc_row_op #(
  parameter int unsigned COLS = 32
) (
  input  logic [COLS-1:0] s_row,
  input  logic [COLS-1:0] b_row,
  input  logic [3:0]      code,
  output logic [COLS-1:0] res_row
);
  for (genvar k = 0; k < COLS; k++) begin : g_pix
    logic [1:0] sel;
    assign sel        = {b_row[k], s_row[k]};
    assign res_row[k] = code[sel];
  end
endmodule

// File: rtl/bmc_compose.sv
module bmc_compose #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32,
  localparam int unsigned PIX = ROWS * COLS
) (
  input  logic [PIX-1:0] s_plane,
  input  logic [PIX-1:0] b_plane,
  input  logic [3:0]     code,
  output logic [PIX-1:0] res_plane
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    bmc_row_op #(.COLS(COLS)) u_row (
      .s_row  (s_plane[r*COLS +: COLS]),
      .b_row  (b_plane[r*COLS +: COLS]),
      .code   (code),
      .res_row(res_plane[r*COLS +: COLS])
    );
  end
endmodule

// File: rtl/bmc_plane_reg.sv
module bmc_plane_reg #(
  parameter int unsigned W = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/bitmap_compositor.sv
module bitmap_compositor
  import bmc_pkg::*;
#(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32,
  localparam int unsigned PIX = ROWS * COLS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     func_code,
  input  logic           dest_sel,
  input  logic           start,
  input  logic           flush,
  input  logic           img_load,
  input  logic [PIX-1:0] img_data,
  output logic [PIX-1:0] buf_plane,
  output logic [PIX-1:0] img_plane,
  output logic [PIX-1:0] scr_plane
);
  logic           rst_sync_n;
  bmc_op_e        op;
  logic           scr_en;
  logic           buf_en;
  logic           img_en;
  logic           img_from_load;
  logic [PIX-1:0] comp_res;
  logic [PIX-1:0] img_d;

  bmc_reset_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  bmc_cmd_arb u_arb (
    .flush        (flush),
    .start        (start),
    .dest_sel     (dest_sel),
    .img_load     (img_load),
    .op           (op),
    .scr_en       (scr_en),
    .buf_en       (buf_en),
    .img_en       (img_en),
    .img_from_load(img_from_load)
  );

  bmc_compose #(.ROWS(ROWS), .COLS(COLS)) u_comp (
    .s_plane  (buf_plane),
    .b_plane  (img_plane),
    .code     (func_code),
    .res_plane(comp_res)
  );

  always_comb begin
    img_d = img_from_load ? img_data : comp_res;
  end

  bmc_plane_reg #(.W(PIX)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .en(buf_en), .d(comp_res), .q(buf_plane)
  );

  bmc_plane_reg #(.W(PIX)) u_img (
    .clk(clk), .rst_n(rst_sync_n), .en(img_en), .d(img_d), .q(img_plane)
  );

  bmc_plane_reg #(.W(PIX)) u_scr (
    .clk(clk), .rst_n(rst_sync_n), .en(scr_en), .d(buf_plane), .q(scr_plane)
  );
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
  parameter int unsigned ROWS = 32,
  parameter int unsigned COLS = 32,
  localparam int unsigned PIX = ROWS * COLS
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush,
  input logic           start,
  input logic           dest_sel,
  input logic           img_load,
  input logic [PIX-1:0] buf_q,
  input logic [PIX-1:0] img_q,
  input logic [PIX-1:0] scr_q
);
  // R6
  flush_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (scr_q == $past(buf_q)));

  // R7
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && start) |=> ($stable(buf_q) && $stable(img_q)));

  // R10
  screen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> $stable(scr_q));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !start && !img_load) |=> ($stable(buf_q) && $stable(img_q)));

  // R5
  img_dest_buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flush && dest_sel) |=> $stable(buf_q));

  // R5
  buf_dest_img_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flush && !dest_sel) |=> $stable(img_q));
endmodule

bind bitmap_compositor bmc_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .flush   (flush),
  .start   (start),
  .dest_sel(dest_sel),
  .img_load(img_load),
  .buf_q   (buf_plane),
  .img_q   (img_plane),
  .scr_q   (scr_plane)
);

// File: tb/tb_bitmap_compositor.sv
`timescale 1ns/1ps
module tb_bitmap_compositor;
  localparam int unsigned ROWS = 32;
  localparam int unsigned COLS = 32;
  localparam int unsigned PIX  = ROWS * COLS;

  logic           clk;
  logic           rst_n;
  logic [3:0]     func_code;
  logic           dest_sel;
  logic           start;
  logic           flush;
  logic           img_load;
  logic [PIX-1:0] img_data;
  logic [PIX-1:0] buf_plane;
  logic [PIX-1:0] img_plane;
  logic [PIX-1:0] scr_plane;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [PIX-1:0] m_buf, m_img, m_scr;
  logic [PIX-1:0] q_buf[$];
  logic [PIX-1:0] q_img[$];
  logic [PIX-1:0] q_scr[$];
  string          q_tag[$];

  bitmap_compositor #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rst_n(rst_n), .func_code(func_code), .dest_sel(dest_sel),
    .start(start), .flush(flush), .img_load(img_load), .img_data(img_data),
    .buf_plane(buf_plane), .img_plane(img_plane), .scr_plane(scr_plane)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [PIX-1:0] table_model(input logic [PIX-1:0] s,
      input logic [PIX-1:0] b, input logic [3:0] c);
    logic [PIX-1:0] r;
    for (int k = 0; k < PIX; k++) r[k] = c[{b[k], s[k]}];
    return r;
  endfunction

  function automatic logic [PIX-1:0] expect_comp(input logic [PIX-1:0] s,
      input logic [PIX-1:0] b, input logic [3:0] c);
    case (c)
      4'b0000: return '0;
      4'b1111: return '1;
      4'b1010: return s;
      4'b1100: return b;
      4'b0110: return s ^ b;
      4'b1110: return s | b;
      4'b0010: return s & ~b;
      4'b0111: return ~(s & b);
      4'b0001: return ~(s | b);
      4'b0101: return ~s;
      default: return table_model(s, b, c);
    endcase
  endfunction

  function automatic logic [PIX-1:0] rand_plane();
    logic [PIX-1:0] p;
    for (int k = 0; k < PIX; k++) p[k] = 1'($urandom % 2);
    return p;
  endfunction

  function automatic logic [PIX-1:0] checker_plane();
    logic [PIX-1:0] p;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) p[r*COLS + c] = 1'((r + c) % 2);
    return p;
  endfunction

  task automatic step(input logic f, input logic s, input logic d,
      input logic [3:0] c, input logic ld, input logic [PIX-1:0] data,
      input string tag);
    if (f)          m_scr = m_buf;
    else if (s) begin
      if (d) m_img = expect_comp(m_buf, m_img, c);
      else   m_buf = expect_comp(m_buf, m_img, c);
    end
    else if (ld)    m_img = data;
    @(negedge clk);
    flush = f; start = s; dest_sel = d; func_code = c; img_load = ld; img_data = data;
    @(posedge clk);
    #1;
    flush = 0; start = 0; img_load = 0;
    q_buf.push_back(m_buf); q_img.push_back(m_img);
    q_scr.push_back(m_scr); q_tag.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q_tag.size() > 0) begin
        logic [PIX-1:0] eb, ei, es;
        string t;
        eb = q_buf.pop_front(); ei = q_img.pop_front();
        es = q_scr.pop_front(); t = q_tag.pop_front();
        checks++;
        if (buf_plane !== eb || img_plane !== ei || scr_plane !== es) begin
          errors++;
          $display("FAIL %s buf act %h exp %h img act %h exp %h scr act %h exp %h",
                   t, buf_plane, eb, img_plane, ei, scr_plane, es);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [PIX-1:0] pa, pb, z;
    z = '0;
    m_buf = '0; m_img = '0; m_scr = '0;
    flush = 0; start = 0; dest_sel = 0; func_code = 0; img_load = 0; img_data = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);

    step(0, 0, 0, 4'h0, 0, z, "R1 reset planes zero");
    pa = rand_plane();
    step(0, 0, 0, 4'h0, 1, pa, "R8 image load");
    step(0, 1, 0, 4'b1111, 0, z, "R3 full to buffer");
    step(0, 1, 0, 4'b0000, 0, z, "R3 clear to buffer");
    step(0, 1, 0, 4'b1100, 0, z, "R4 draw copies image");
    step(0, 0, 0, 4'h0, 0, z, "R9 idle hold");

    for (int pat = 0; pat < 2; pat++) begin
      for (int c = 0; c < 16; c++) begin
        pa = (pat == 0) ? rand_plane() : checker_plane();
        pb = rand_plane();
        step(0, 0, 0, 4'h0, 1, pa, "R8 load s source");
        step(0, 1, 0, 4'b1100, 0, z, "R4 draw to buffer");
        step(0, 0, 0, 4'h0, 1, pb, "R8 load b source");
        step(0, 1, 0, 4'(c), 0, z, "R2 R3 R4 code to buffer");
      end
    end

    pb = rand_plane();
    step(0, 0, 0, 4'h0, 1, pb, "R8 load");
    step(0, 1, 1, 4'b0110, 0, z, "R5 toggle to image, buffer kept");
    step(0, 1, 1, 4'b0101, 0, z, "R5 R4 negative to image");
    step(1, 0, 0, 4'h0, 0, z, "R6 flush copies buffer");
    step(0, 1, 0, 4'b1111, 0, z, "R10 compose leaves screen");
    step(0, 0, 0, 4'h0, 1, rand_plane(), "R10 load leaves screen");
    step(1, 1, 0, 4'b0000, 0, z, "R7 flush beats compose buffer");
    step(1, 1, 1, 4'b0000, 0, z, "R7 flush beats compose image");
    step(0, 1, 1, 4'b1010, 1, rand_plane(), "R8 load ignored under start");
    step(1, 0, 0, 4'h0, 1, rand_plane(), "R8 load ignored under flush");
    step(0, 0, 0, 4'h0, 0, z, "R9 idle hold end");

    repeat (3) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule